// File: doc/BRIEF.md
# Signed Integer Encoding Converter

This block translates an integer word from one signed encoding into another. It accepts five encodings: sign-and-magnitude, ones' complement, two's complement, biased (excess-half-range) and zig-zag, where the sign sits in the least significant bit. Each word carries a 3-bit source-format code and a 3-bit destination-format code. Internally the word is reduced to a canonical sign and an unsigned magnitude, and that pair is then encoded in the destination format.

Two corner cases get flags. The most negative value, -2^(W-1), exists only in the encodings with one zero, so a conversion into an encoding that cannot hold it raises a range error. A negative-zero input raises a flag of its own and is always re-emitted as positive zero. An optional output register, selected by a parameter and enabled by default, adds one cycle of latency and carries a valid strobe alongside the data.

Top module: `fmt_xcode`

## Requirements
- R1: Format code 0 is sign-and-magnitude: bit W-1 is the sign (1 = negative) and bits W-2..0 hold the magnitude. With W=8, +43 is 0x2B and -43 is 0xAB.
- R2: Format code 1 is ones' complement: a negative value is the bitwise inverse of its positive counterpart. With W=8, -43 is 0xD4.
- R3: Format code 2 is two's complement, covering -2^(W-1) to 2^(W-1)-1. With W=8, -2 is 0xFE.
- R4: Format code 3 is biased: the value v is stored as the unsigned number v+2^(W-1). Zero is 0x80 and -128 is 0x00 at W=8.
- R5: Format code 4 is zig-zag: a value v >= 0 is stored as 2v and a value v < 0 as -2v-1. So 0, -1, 1 and -2 map to 0, 1, 2 and 3.
- R6: For every source and destination pair and every input word whose value the destination can hold, data_out encodes the same integer value as data_in, and range_err is 0.
- R7: When the input value is -2^(W-1) and the destination is format 0 or 1, range_err is 1 and data_out is all zeros. In every other case range_err is 0.
- R8: A negative-zero input (format 0 with word 100..0, or format 1 with all ones) sets neg_zero and produces the destination's positive-zero word. neg_zero is 0 for every other input.
- R9: Unused format codes 5, 6 and 7, on either side, behave as two's complement (code 2).
- R10: With the output register enabled, data_out, range_err and neg_zero show the result of a word one clock after that word's valid_in, and valid_out equals valid_in delayed by one clock.
- R11: With the output register enabled, a clock edge with valid_in low leaves data_out, range_err and neg_zero unchanged.
- R12: A synchronous active-low reset clears valid_out, data_out, range_err and neg_zero to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Input word is present this cycle |
| src_fmt | input | 3 | Encoding of data_in (0 sign-magnitude, 1 ones', 2 two's, 3 biased, 4 zig-zag) |
| dst_fmt | input | 3 | Encoding wanted on data_out, same codes |
| data_in | input | W | Word to convert |
| valid_out | output | 1 | data_out and the flags carry a result |
| data_out | output | W | Converted word |
| range_err | output | 1 | Destination cannot hold the input value |
| neg_zero | output | 1 | Input was a negative zero |

## Verification
The hardest cases to reach are the two single words that trigger a flag: the most negative value headed for a dual-zero encoding, and a negative zero whose source is format 0 or 1. In each source format such a value is one particular bit pattern among 2^W words. The stimulus therefore sweeps every input word for all 64 pairs of format codes, with the unused codes included, so that every flagged word meets every destination. Directed vectors come first. They cover the published example encodings, the latency and hold of the output register, and the reset state.

// File: rtl/fmt_pkg.sv
// Shared encoding identifiers for the signed-format converter.
// Assumes a 3-bit format code; codes outside the five defined ones
// fold onto two's complement.
package fmt_pkg;

    typedef enum logic [2:0] {
        FMT_SIGNMAG = 3'd0,
        FMT_ONESC   = 3'd1,
        FMT_TWOSC   = 3'd2,
        FMT_BIASED  = 3'd3,
        FMT_ZIGZAG  = 3'd4
    } fmt_e;

    // Map a raw select code onto a defined format (R9: spare codes -> two's complement).
    function automatic fmt_e to_fmt(input logic [2:0] code);
        fmt_e f;
        case (code)
            3'd0:    f = FMT_SIGNMAG;
            3'd1:    f = FMT_ONESC;
            3'd3:    f = FMT_BIASED;
            3'd4:    f = FMT_ZIGZAG;
            default: f = FMT_TWOSC;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/fmt_decode.sv
// Decoder: turns a W-bit word of the selected encoding into a canonical
// sign and an unsigned W-bit magnitude (wide enough for 2^(W-1)).
// Negative zero is detected and folded to positive zero, so that a set
// sign always comes with a non-zero magnitude. Purely combinational.
// Assumes W >= 2.
module fmt_decode
    import fmt_pkg::*;
#(
    parameter int W = 8
) (
    input  fmt_e           fmt,
    input  logic [W-1:0]   code,
    output logic           sgn,
    output logic [W-1:0]   mag,
    output logic           negz
);
    localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic           raw_sgn;
    logic [W-1:0]   raw_mag;
    logic [W-1:0]   tc_word;
    logic [W-1:0]   half;

    // Reinterpret the biased form as two's complement by flipping the MSB.
    always_comb tc_word = (fmt == FMT_BIASED) ? (code ^ MSB_MASK) : code;

    // Zig-zag word shifted right by one: the magnitude before sign correction.
    always_comb half = {1'b0, code[W-1:1]};

    // Per-format extraction of sign and magnitude.
    always_comb begin
        raw_sgn = 1'b0;
        raw_mag = '0;
        case (fmt)
            FMT_SIGNMAG: begin
                raw_sgn = code[W-1];
                raw_mag = {1'b0, code[W-2:0]};
            end
            FMT_ONESC: begin
                raw_sgn = code[W-1];
                raw_mag = code[W-1] ? ~code : code;
            end
            FMT_ZIGZAG: begin
                raw_sgn = code[0];
                raw_mag = code[0] ? (half + ONE) : half;
            end
            default: begin
                raw_sgn = tc_word[W-1];
                raw_mag = tc_word[W-1] ? (~tc_word + ONE) : tc_word;
            end
        endcase
    end

    // Fold a negative zero to the canonical positive zero (R8).
    always_comb begin
        negz = raw_sgn && (raw_mag == '0);
        sgn  = raw_sgn && !negz;
        mag  = raw_mag;
    end

endmodule

// File: rtl/fmt_encode.sv
// Encoder: builds the W-bit word of the selected encoding from a
// canonical sign and magnitude. Assumes the magnitude is at most
// 2^(W-2)... up to 2^(W-1) when negative and at most 2^(W-1)-1 when
// positive, and that the sign is clear for zero. The value -2^(W-1) has
// no form in the dual-zero encodings: it raises oor and drives zeros.
// Purely combinational. Assumes W >= 2.
module fmt_encode
    import fmt_pkg::*;
#(
    parameter int W = 8
) (
    input  fmt_e           fmt,
    input  logic           sgn,
    input  logic [W-1:0]   mag,
    output logic [W-1:0]   code,
    output logic           oor
);
    localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic           is_min;
    logic [W-1:0]   tc_word;
    logic [W-1:0]   dbl;
    logic [W-1:0]   low_mag;

    // Detect the one value the dual-zero encodings cannot hold (R7).
    always_comb is_min = sgn && (mag == MSB_MASK);

    // Shared two's-complement form, also the base of the biased form.
    always_comb tc_word = sgn ? (~mag + ONE) : mag;

    // Magnitude doubled for zig-zag, and the magnitude without its MSB.
    always_comb begin
        dbl     = {mag[W-2:0], 1'b0};
        low_mag = {1'b0, mag[W-2:0]};
    end

    // Per-format word assembly.
    always_comb begin
        oor  = 1'b0;
        code = '0;
        case (fmt)
            FMT_SIGNMAG: begin
                oor  = is_min;
                code = is_min ? '0 : {sgn, mag[W-2:0]};
            end
            FMT_ONESC: begin
                oor  = is_min;
                code = is_min ? '0 : (sgn ? ~low_mag : low_mag);
            end
            FMT_BIASED: code = tc_word ^ MSB_MASK;
            FMT_ZIGZAG: code = sgn ? (dbl - ONE) : dbl;
            default:    code = tc_word;
        endcase
    end

endmodule

// File: rtl/fmt_outreg.sv
// Output stage. With REG_OUT=1 the result and flags are captured on a
// clock edge where valid_in is high and held otherwise, and valid_out
// follows valid_in one clock later. With REG_OUT=0 everything passes
// straight through. Reset is synchronous and active low.
module fmt_outreg #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           valid_in,
    input  logic [W-1:0]   d_code,
    input  logic           d_oor,
    input  logic           d_negz,
    output logic           valid_out,
    output logic [W-1:0]   q_code,
    output logic           q_oor,
    output logic           q_negz
);
    generate
        if (REG_OUT) begin : g_reg
            // Capture on valid, hold otherwise, clear on reset (R10, R11, R12).
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_out <= 1'b0;
                    q_code    <= '0;
                    q_oor     <= 1'b0;
                    q_negz    <= 1'b0;
                end else begin
                    valid_out <= valid_in;
                    if (valid_in) begin
                        q_code <= d_code;
                        q_oor  <= d_oor;
                        q_negz <= d_negz;
                    end
                end
            end

            // R10: the strobe is the input strobe one clock later.
            p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
                valid_in |=> valid_out);
            p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !valid_in |=> !valid_out);
            // R10: the captured word is the one presented with valid_in.
            p_data_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
                valid_in |=> (q_code == $past(d_code)));
            // R11: no valid, no change.
            p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
                !valid_in |=> ($stable(q_code) && $stable(q_oor) && $stable(q_negz)));
        end else begin : g_comb
            // Pass-through variant: no latency.
            always_comb begin
                valid_out = valid_in;
                q_code    = d_code;
                q_oor     = d_oor;
                q_negz    = d_negz;
            end
        end
    endgenerate

endmodule

// File: rtl/fmt_xcode.sv
// Signed-format converter top. Decodes data_in from the src_fmt encoding
// to a canonical sign/magnitude, encodes it into the dst_fmt encoding,
// flags the unrepresentable case and negative-zero inputs, and passes the
// result through an optional output register.
// Assumes W >= 2; format codes 5..7 act as two's complement.
module fmt_xcode
    import fmt_pkg::*;
#(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           valid_in,
    input  logic [2:0]     src_fmt,
    input  logic [2:0]     dst_fmt,
    input  logic [W-1:0]   data_in,
    output logic           valid_out,
    output logic [W-1:0]   data_out,
    output logic           range_err,
    output logic           neg_zero
);
    localparam logic [W-1:0] MIN_MAG = {1'b1, {(W-1){1'b0}}};

    fmt_e           src_e;
    fmt_e           dst_e;
    logic           c_sgn;
    logic [W-1:0]   c_mag;
    logic           c_negz;
    logic [W-1:0]   e_code;
    logic           e_oor;

    // Resolve the raw select codes to defined formats.
    always_comb begin
        src_e = to_fmt(src_fmt);
        dst_e = to_fmt(dst_fmt);
    end

    fmt_decode #(.W(W)) dec_i (
        .fmt  (src_e),
        .code (data_in),
        .sgn  (c_sgn),
        .mag  (c_mag),
        .negz (c_negz)
    );

    fmt_encode #(.W(W)) enc_i (
        .fmt  (dst_e),
        .sgn  (c_sgn),
        .mag  (c_mag),
        .code (e_code),
        .oor  (e_oor)
    );

    fmt_outreg #(.W(W), .REG_OUT(REG_OUT)) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .d_code    (e_code),
        .d_oor     (e_oor),
        .d_negz    (c_negz),
        .valid_out (valid_out),
        .q_code    (data_out),
        .q_oor     (range_err),
        .q_negz    (neg_zero)
    );

    // R6: the canonical form never carries a signed zero.
    p_canon_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_sgn |-> (c_mag != '0));
    // R6: a positive canonical magnitude stays below 2^(W-1).
    p_canon_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !c_sgn |-> (c_mag < MIN_MAG));
    // R7: a range error only comes from the most negative value.
    p_oor_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        e_oor |-> (c_sgn && c_mag == MIN_MAG));
    // R7: a flagged output word is all zeros.
    p_oor_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> (data_out == '0));
    // R8: a negative zero reaches the encoder as positive zero.
    p_negz_canon_r8: assert property (@(posedge clk) disable iff (!rst_n)
        c_negz |-> (!c_sgn && c_mag == '0 && !e_oor));
    // R8: only the dual-zero source formats can report a negative zero.
    p_negz_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        c_negz |-> (src_e == FMT_SIGNMAG || src_e == FMT_ONESC));

endmodule

// File: tb/fmt_xcode_tb_top.sv
// Self-checking bench: directed vectors, then an exhaustive sweep of all
// 8x8 format-code pairs and all 256 input words at W=8.
module fmt_xcode_tb_top;
    localparam int W       = 8;
    localparam int CLK_PER = 10;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           valid_in;
    logic [2:0]     src_fmt;
    logic [2:0]     dst_fmt;
    logic [W-1:0]   data_in;
    logic           valid_out;
    logic [W-1:0]   data_out;
    logic           range_err;
    logic           neg_zero;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    fmt_xcode #(.W(W), .REG_OUT(1'b1)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .src_fmt   (src_fmt),
        .dst_fmt   (dst_fmt),
        .data_in   (data_in),
        .valid_out (valid_out),
        .data_out  (data_out),
        .range_err (range_err),
        .neg_zero  (neg_zero)
    );

    // Integer value of word x in format code f (codes 5..7 act as code 2, R9).
    function automatic int val_of(input int f, input int x);
        case (f)
            0:       return (x >= 128) ? -(x - 128) : x;
            1:       return (x >= 128) ? -(255 - x) : x;
            3:       return x - 128;
            4:       return (x % 2 == 0) ? x / 2 : -((x + 1) / 2);
            default: return (x >= 128) ? x - 256 : x;
        endcase
    endfunction

    // Expected {range_err, neg_zero, data_out} for a conversion.
    function automatic int expect_of(input int s, input int d, input int x);
        int v;
        int nz;
        int w;
        int df;
        df = (d > 4) ? 2 : d;
        nz = ((s == 0 && x == 128) || (s == 1 && x == 255)) ? 1 : 0;
        v  = val_of(s, x);
        if (v == -128 && (df == 0 || df == 1)) return 512;
        case (df)
            0:       w = (v < 0) ? 128 - v : v;
            1:       w = (v < 0) ? 255 + v : v;
            3:       w = v + 128;
            4:       w = (v >= 0) ? 2 * v : -2 * v - 1;
            default: w = (v + 256) % 256;
        endcase
        return nz * 256 + w;
    endfunction

    function automatic string tag_of(input int s, input int d, input int x);
        int e;
        e = expect_of(s, d, x);
        if (e >= 512)              return "R7";
        if (e >= 256)              return "R8";
        if (s > 4 || d > 4)        return "R9";
        return "R6";
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int observed();
        return {22'd0, range_err, neg_zero, data_out};
    endfunction

    // Present one word with valid and check the registered result a clock later.
    task automatic run(input int s, input int d, input int x, input string tag, input int exp);
        @(negedge clk);
        valid_in = 1'b1;
        src_fmt  = 3'(s);
        dst_fmt  = 3'(d);
        data_in  = 8'(x);
        @(negedge clk);
        chk(tag, observed(), exp);
        if (!valid_out) chk("R10", 0, 1);
    endtask

    initial begin
        rst_n    = 1'b0;
        valid_in = 1'b1;
        src_fmt  = 3'd2;
        dst_fmt  = 3'd0;
        data_in  = 8'h80;
        repeat (3) @(negedge clk);
        // R12: reset clears every output even with valid_in high
        chk("R12", {23'd0, valid_out, range_err, neg_zero, data_out}, 0);
        rst_n    = 1'b1;
        valid_in = 1'b0;

        // R1..R5: encodings of known values
        run(2, 0, 8'h2B, "R1", 8'h2B);
        run(2, 0, 8'hD5, "R1", 8'hAB);
        run(2, 1, 8'hD5, "R2", 8'hD4);
        run(0, 2, 8'h82, "R3", 8'hFE);
        run(2, 3, 8'h80, "R4", 8'h00);
        run(2, 3, 8'h00, "R4", 8'h80);
        run(2, 4, 8'hFF, "R5", 8'h01);
        run(2, 4, 8'h01, "R5", 8'h02);
        run(2, 4, 8'hFE, "R5", 8'h03);
        // R7: most negative value into dual-zero formats
        run(3, 0, 8'h00, "R7", 512);
        run(4, 1, 8'hFF, "R7", 512);
        // R8: negative zeros
        run(0, 3, 8'h80, "R8", 256 + 8'h80);
        run(1, 1, 8'hFF, "R8", 256);
        // R9: spare codes act as two's complement
        run(6, 0, 8'hD5, "R9", 8'hAB);

        // R10/R11: drop valid with a different word, expect no update
        @(negedge clk);
        valid_in = 1'b0;
        src_fmt  = 3'd0;
        data_in  = 8'h80;
        @(negedge clk);
        chk("R10", {31'd0, valid_out}, 0);
        chk("R11", observed(), 8'hAB);
        @(negedge clk);
        chk("R11", observed(), 8'hAB);

        // R6..R9: exhaustive sweep
        for (int s = 0; s < 8; s++)
            for (int d = 0; d < 8; d++)
                for (int x = 0; x < 256; x++)
                    run(s, d, x, tag_of(s, d, x), expect_of(s, d, x));

        @(negedge clk);
        valid_in = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule